// File: doc/BRIEF.md
# Multiplier-Based Variable Left Shifter

This block shifts an unsigned 24-bit data word left by 0 to 15 bit positions. It does not use a cascade of multiplexers. It turns the 4-bit shift amount into a 16-bit one-hot word, where bit i is set only when the amount equals i. It then multiplies the data word by that power of two. This form maps onto a hard multiplier, and the only logic the shift amount needs is a small decoder.

The product is kept at its full 40-bit width, so bits shifted past bit 23 stay in the result. The `PIPE_STAGES` parameter adds 0, 1 or 2 register stages. The first stage sits after the decoder and the second after the multiplier, so the block can be tuned for a higher clock rate. The valid strobe is delayed by the same number of cycles, so the logic that drives the block knows exactly when each result appears.

Top module: `lsh_mul_shift`

## Requirements
- R1: When `valid_o` is 1, `result_o` equals the 40-bit zero-extended `data_i` shifted left by `shamt_i`, where both inputs are taken from the cycle `PIPE_STAGES` clocks earlier.
- R2: No set bit is lost. A shift of 15 applied to 0xFFFFFF yields 0x7FFFFF8000, and the count of ones in `result_o` equals the count of ones in the data word that produced it.
- R3: The `shamt` low-order bits of a valid result, left empty by the shift, are always 0.
- R4: `valid_o` equals `valid_i` delayed by exactly `PIPE_STAGES` clock cycles, which is 2 by default, including any gaps in the input stream.
- R5: While `rst_ni` is 0, `valid_o` is 0. After reset is released, `valid_o` stays 0 until a strobed input has passed through the pipeline.
- R6: A shift amount of 0 returns the data word unchanged in bits 23:0, with bits 39:24 at 0.
- R7: Inputs presented on consecutive cycles produce results on consecutive cycles, in the same order, with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears only the valid pipeline |
| valid_i | input | 1 | Input strobe marking `data_i` and `shamt_i` as valid |
| data_i | input | 24 | Unsigned data word to shift |
| shamt_i | input | 4 | Left shift amount, 0 to 15 |
| valid_o | output | 1 | Result strobe, `PIPE_STAGES` cycles after `valid_i` |
| result_o | output | 40 | Full-width shifted result |

## Verification
On every cycle, the assertions compare each valid result with an independently delayed copy of the inputs. This covers the shifted value, the zero fill of the empty low bits, the preserved count of ones, and the exact alignment of the valid strobe with the input strobe. They also check that the strobe stays low during reset. Only the bench scenarios show the following: that every shift amount from 0 to 15 works on varied data, that the edge values are correct (all ones shifted by 15, shift by 0, a single bit moved to the top), that a gapped back-to-back stream keeps its order, and that a reset in the middle of a stream flushes the results still in flight.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  localparam int unsigned DATA_W_DEF  = 24;
  localparam int unsigned SHIFT_W_DEF = 4;
  localparam int unsigned PIPE_DEF    = 2;

  function automatic int unsigned onehot_width(input int unsigned shift_w);
    return 32'd1 << shift_w;
  endfunction
endpackage

// File: rtl/lsh_onehot_dec.sv
module lsh_onehot_dec #(
  parameter int unsigned SHIFT_W  = 4,
  parameter int unsigned ONEHOT_W = 16
) (
  input  logic [SHIFT_W-1:0]  shamt_i,
  output logic [ONEHOT_W-1:0] onehot_o
);
  for (genvar i = 0; i < ONEHOT_W; i++) begin : g_bit
    assign onehot_o[i] = (shamt_i == SHIFT_W'(i));
  end
endmodule

// File: rtl/lsh_mul.sv
module lsh_mul #(
  parameter int unsigned A_W     = 24,
  parameter int unsigned B_W     = 16,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned P_W    = A_W + B_W
) (
  input  logic           clk_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] p_o
);
  logic [P_W-1:0] prod;

  assign prod = P_W'(a_i) * P_W'(b_i);

  if (OUT_REG) begin : g_reg
    logic [P_W-1:0] prod_q;
    // data path left unreset on purpose
    always_ff @(posedge clk_i) prod_q <= prod;
    assign p_o = prod_q;
  end else begin : g_comb
    assign p_o = prod;
  end
endmodule

// File: rtl/lsh_valid_pipe.sv
module lsh_valid_pipe #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic valid_o
);
  if (DEPTH == 0) begin : g_none
    assign valid_o = valid_i;
  end else begin : g_sr
    logic [DEPTH-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sr_q <= '0;
      end else begin
        sr_q[0] <= valid_i;
        for (int k = 1; k < DEPTH; k++) sr_q[k] <= sr_q[k-1];
      end
    end
    assign valid_o = sr_q[DEPTH-1];
  end
endmodule

// File: rtl/lsh_mul_shift.sv
module lsh_mul_shift
  import lsh_pkg::*;
#(
  parameter int unsigned DATA_W      = DATA_W_DEF,
  parameter int unsigned SHIFT_W     = SHIFT_W_DEF,
  parameter int unsigned PIPE_STAGES = PIPE_DEF,
  localparam int unsigned ONEHOT_W   = onehot_width(SHIFT_W),
  localparam int unsigned PROD_W     = DATA_W + ONEHOT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHIFT_W-1:0] shamt_i,
  output logic               valid_o,
  output logic [PROD_W-1:0]  result_o
);
  localparam bit DEC_REG = (PIPE_STAGES >= 1);
  localparam bit MUL_REG = (PIPE_STAGES >= 2);

  logic [ONEHOT_W-1:0] onehot;
  logic [ONEHOT_W-1:0] onehot_s1;
  logic [DATA_W-1:0]   data_s1;

  lsh_onehot_dec #(
    .SHIFT_W (SHIFT_W),
    .ONEHOT_W(ONEHOT_W)
  ) dec_i (
    .shamt_i (shamt_i),
    .onehot_o(onehot)
  );

  if (DEC_REG) begin : g_dec_reg
    logic [ONEHOT_W-1:0] onehot_q;
    logic [DATA_W-1:0]   data_q;
    always_ff @(posedge clk_i) begin
      onehot_q <= onehot;
      data_q   <= data_i;
    end
    assign onehot_s1 = onehot_q;
    assign data_s1   = data_q;
  end else begin : g_dec_comb
    assign onehot_s1 = onehot;
    assign data_s1   = data_i;
  end

  lsh_mul #(
    .A_W    (DATA_W),
    .B_W    (ONEHOT_W),
    .OUT_REG(MUL_REG)
  ) mul_i (
    .clk_i(clk_i),
    .a_i  (data_s1),
    .b_i  (onehot_s1),
    .p_o  (result_o)
  );

  lsh_valid_pipe #(
    .DEPTH(PIPE_STAGES)
  ) vpipe_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/lsh_mul_shift_chk.sv
module lsh_mul_shift_chk #(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned SHIFT_W     = 4,
  parameter int unsigned PIPE_STAGES = 2,
  parameter int unsigned PROD_W      = 40
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [DATA_W-1:0]  data_i,
  input logic [SHIFT_W-1:0] shamt_i,
  input logic               valid_o,
  input logic [PROD_W-1:0]  result_o
);
  logic [DATA_W-1:0]  d_dly;
  logic [SHIFT_W-1:0] s_dly;
  logic               v_dly;

  if (PIPE_STAGES == 0) begin : g_nodly
    assign d_dly = data_i;
    assign s_dly = shamt_i;
    assign v_dly = valid_i;
  end else begin : g_dly
    logic [PIPE_STAGES-1:0][DATA_W-1:0]  d_sr;
    logic [PIPE_STAGES-1:0][SHIFT_W-1:0] s_sr;
    logic [PIPE_STAGES-1:0]              v_sr;
    always_ff @(posedge clk_i) begin
      d_sr[0] <= data_i;
      s_sr[0] <= shamt_i;
      for (int k = 1; k < PIPE_STAGES; k++) begin
        d_sr[k] <= d_sr[k-1];
        s_sr[k] <= s_sr[k-1];
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_sr <= '0;
      end else begin
        v_sr[0] <= valid_i;
        for (int k = 1; k < PIPE_STAGES; k++) v_sr[k] <= v_sr[k-1];
      end
    end
    assign d_dly = d_sr[PIPE_STAGES-1];
    assign s_dly = s_sr[PIPE_STAGES-1];
    assign v_dly = v_sr[PIPE_STAGES-1];
  end

  logic [PROD_W-1:0] exp_res;
  logic [PROD_W-1:0] low_mask;
  assign exp_res  = PROD_W'(d_dly) << s_dly;
  assign low_mask = (PROD_W'(1) << s_dly) - PROD_W'(1);

  AST_SHIFT_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (result_o == exp_res)); // R1
  AST_ONES_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(result_o) == $countones(d_dly))); // R2
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((result_o & low_mask) == '0)); // R3
  AST_VALID_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_dly); // R4
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o); // R5
endmodule

bind lsh_mul_shift lsh_mul_shift_chk #(
  .DATA_W     (DATA_W),
  .SHIFT_W    (SHIFT_W),
  .PIPE_STAGES(PIPE_STAGES),
  .PROD_W     (PROD_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .data_i  (data_i),
  .shamt_i (shamt_i),
  .valid_o (valid_o),
  .result_o(result_o)
);

// File: tb/lsh_mul_shift_tb_top.sv
module lsh_mul_shift_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned LAT        = 2;
  localparam int unsigned DW         = 24;
  localparam int unsigned SW         = 4;
  localparam int unsigned PW         = 40;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [SW-1:0] shamt_i = '0;
  logic          valid_o;
  logic [PW-1:0] result_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [PW-1:0] exp_r [64];
  logic          exp_v [64];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lsh_mul_shift #(.PIPE_STAGES(LAT)) dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .shamt_i (shamt_i),
    .valid_o (valid_o),
    .result_o(result_o)
  );

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drives n items (one per cycle) from the stimulus arrays, checks each output LAT cycles later
  task automatic run_seq(input int n, input logic [DW-1:0] d [64], input logic [SW-1:0] s [64],
                         input logic v [64], input string req);
    for (int i = 0; i < n; i++) begin
      exp_v[i] = v[i];
      exp_r[i] = PW'(d[i]) << s[i];
    end
    for (int i = 0; i < n + int'(LAT); i++) begin
      @(negedge clk_i);
      if (i < n) begin
        valid_i = v[i]; data_i = d[i]; shamt_i = s[i];
      end else begin
        valid_i = 1'b0;
      end
      #1;
      if (i >= int'(LAT)) begin
        check(valid_o == exp_v[i-LAT], {req, " valid (R4)"}, PW'(valid_o), PW'(exp_v[i-LAT]));
        if (exp_v[i-LAT])
          check(result_o == exp_r[i-LAT], req, result_o, exp_r[i-LAT]);
      end
    end
  endtask

  task automatic t_reset_state();
    #1;
    check(valid_o == 1'b0, "R5 in reset", PW'(valid_o), '0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < int'(LAT) + 1; i++) begin
      @(negedge clk_i);
      check(valid_o == 1'b0, "R5 after release", PW'(valid_o), '0);
    end
  endtask

  task automatic t_sweep();
    logic [DW-1:0] d [64];
    logic [SW-1:0] s [64];
    logic          v [64];
    for (int i = 0; i < 16; i++) begin
      d[i] = DW'($urandom) | DW'(1);
      s[i] = SW'(i);
      v[i] = 1'b1;
    end
    run_seq(16, d, s, v, "R1 sweep"); // R7 back-to-back stream
  endtask

  task automatic t_edges();
    logic [DW-1:0] d [64];
    logic [SW-1:0] s [64];
    logic          v [64];
    d[0] = 24'hFFFFFF; s[0] = 4'd15; v[0] = 1'b1; // R2
    d[1] = 24'hA5C3E1; s[1] = 4'd0;  v[1] = 1'b1; // R6
    d[2] = 24'h800000; s[2] = 4'd15; v[2] = 1'b1; // R2 top bit
    d[3] = 24'h000001; s[3] = 4'd9;  v[3] = 1'b1; // R3
    run_seq(4, d, s, v, "R2 R6 edges");
    @(negedge clk_i);
    valid_i = 1'b1; data_i = 24'hFFFFFF; shamt_i = 4'd15;
    repeat (LAT) @(posedge clk_i);
    @(negedge clk_i); valid_i = 1'b0;
    check(result_o == 40'h7FFFFF8000, "R2 all ones", result_o, 40'h7FFFFF8000);
    check(result_o[14:0] == '0, "R3 low zero", PW'(result_o[14:0]), '0);
    @(negedge clk_i);
    valid_i = 1'b1; data_i = 24'h5A5A5A; shamt_i = 4'd0;
    repeat (LAT) @(posedge clk_i);
    @(negedge clk_i); valid_i = 1'b0;
    check(result_o == 40'h00005A5A5A, "R6 zero shift", result_o, 40'h00005A5A5A);
  endtask

  task automatic t_gaps();
    logic [DW-1:0] d [64];
    logic [SW-1:0] s [64];
    logic          v [64];
    for (int i = 0; i < 20; i++) begin
      d[i] = DW'($urandom);
      s[i] = SW'($urandom);
      v[i] = (i % 3) != 1;
    end
    run_seq(20, d, s, v, "R7 gapped stream");
  endtask

  task automatic t_mid_reset();
    @(negedge clk_i);
    valid_i = 1'b1; data_i = 24'h123456; shamt_i = 4'd3;
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check(valid_o == 1'b0, "R5 flush during reset", PW'(valid_o), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < int'(LAT) + 1; i++) begin
      @(negedge clk_i);
      check(valid_o == 1'b0, "R5 flushed item gone", PW'(valid_o), '0);
    end
  endtask

  initial begin
    t_reset_state();
    t_sweep();
    t_edges();
    t_gaps();
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule